// File: doc/BRIEF.md
# Timed Single-Shot DMA Engine

This block copies one contiguous run of bytes between a 4 KiB on-chip scratch buffer and host memory. Software sets up a source address, a destination address and a byte count through a small register port. It then writes a command word that starts the copy, picks the direction, and can ask for an interrupt at the end. The scratch buffer has no port of its own. Its contents are reached through a fixed local address window starting at 0x40000.

A command does not start at once. The engine waits a fixed, parameterised number of cycles and then checks the local range against the window. If the range is valid, it moves one byte per handshake over a ready/valid host master port. A read on that port waits for a separate response strobe. Host addresses are masked to a configurable width before they leave the block. While a command is running, the whole register set is frozen. When the copy finishes, the engine clears its run flag and, if asked, raises the DMA interrupt bit for one cycle.

Top module: `dma_timed_engine`

## Requirements
- R1: After reset, the source, destination, count and command registers all read 0, `hm_req_valid` is 0 and `irq_set` is 0.
- R2: The source, destination, count and command registers sit at offsets 0x80, 0x88, 0x90 and 0x98. A write with `reg_wr_wide`=1 stores all 64 bits. A write with `reg_wr_wide`=0 stores the low 32 bits, zero-extended. `reg_rdata` shows the register selected by `reg_addr`.
- R3: While command bit 0 (run) is 1, a write to any register leaves every register unchanged.
- R4: A write to the command register with bit 0 equal to 0 is discarded. The command value does not change and no host request follows.
- R5: Command bit 1 selects the direction. With bit 1 = 0, bytes are copied from the host at the source address into the buffer at the destination address. With bit 1 = 1, bytes are copied from the buffer at the source address to the host at the destination address. A copy in followed by a copy out returns the original bytes.
- R6: Let L be the local-side address and C the count. The range is accepted only when all of these hold: 0x40000 ≤ L, L + C ≤ 0x41000, C ≠ 0, and L + C does not wrap in 64 bits. The buffer byte used is L − 0x40000 + i.
- R7: A rejected range clears run, sets command bit 3 (error), issues no host request and raises no interrupt. Bit 3 stays set until a later accepted command write replaces the command value.
- R8: The host address of byte i is (host register + i) AND `HOST_MASK`. The default mask is 0x0FFF_FFFF.
- R9: After the clock edge that accepts a command, `hm_req_valid` first goes high after clock edge number `START_DELAY`+1.
- R10: Each accepted request (`hm_req_valid` and `hm_req_ready` both high) moves one byte, in ascending order. A low `hm_req_ready` stalls the engine. A read waits for `hm_rsp_valid` before the next request. No request appears while run is 0.
- R11: When the last byte is done, run clears. On that same edge `irq_set` becomes 0x0000_0100 for exactly one cycle, but only if command bit 2 was 1. Otherwise `irq_set` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_wide | input | 1 | 1 = 64-bit write, 0 = 32-bit write |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the register at `reg_addr` |
| hm_req_valid | output | 1 | Host byte request valid |
| hm_req_ready | input | 1 | Host accepts the request |
| hm_req_write | output | 1 | 1 = write byte to host, 0 = read byte |
| hm_req_addr | output | 64 | Masked host byte address |
| hm_req_wdata | output | 8 | Byte written to host |
| hm_rsp_valid | input | 1 | Read response strobe |
| hm_rsp_data | input | 8 | Read response byte |
| irq_set | output | 32 | One-cycle interrupt request vector (bit 8 = DMA done) |

## Verification
The bench builds the engine with `START_DELAY` = 5, so dozens of transfers fit in a short run, and the exact start-latency edge can still be counted. The buffer size, window base and 28-bit host mask keep their defaults. This puts the window's upper edge (0x41000) and the mask wrap from 0x0FFF_FFFF to 0 within reach of directed cases. Random host stalls and response delays of 0 to 2 cycles exercise the handshake paths.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam logic [7:0] OFF_SRC = 8'h80;
  localparam logic [7:0] OFF_DST = 8'h88;
  localparam logic [7:0] OFF_CNT = 8'h90;
  localparam logic [7:0] OFF_CMD = 8'h98;

  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IEN = 2;
  localparam int CMD_ERR = 3;

  localparam int IRQ_DONE_BIT = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CHECK,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_WR_REQ
  } dma_state_e;
endpackage

// File: rtl/dma_eng_regs.sv
module dma_eng_regs
  import dma_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_wide,
  input  logic [7:0]  addr,
  input  logic [63:0] wdata,
  input  logic        clr_run,
  input  logic        set_err,
  output logic [63:0] rdata,
  output logic [63:0] src_q,
  output logic [63:0] dst_q,
  output logic [63:0] cnt_q,
  output logic        cmd_run,
  output logic        cmd_dir,
  output logic        cmd_ien,
  output logic        cmd_err,
  output logic        start
);
  logic [63:0] cmd_q;
  logic [63:0] src_d, dst_d, cnt_d, cmd_d, wval;
  logic        wr_ok, upd;

  assign wval  = wr_wide ? wdata : {32'h0, wdata[31:0]};
  assign wr_ok = wr_en && !cmd_q[CMD_RUN];
  assign upd   = wr_ok || clr_run || set_err;

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    cmd_d = cmd_q;
    start = 1'b0;
    if (wr_ok) begin
      case (addr)
        OFF_SRC: src_d = wval;
        OFF_DST: dst_d = wval;
        OFF_CNT: cnt_d = wval;
        OFF_CMD: if (wval[CMD_RUN]) begin
                   cmd_d = wval;
                   start = 1'b1;
                 end
        default: ;
      endcase
    end
    if (clr_run) cmd_d[CMD_RUN] = 1'b0;
    if (set_err) cmd_d[CMD_ERR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      cmd_q <= '0;
    end else if (upd) begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
      cmd_q <= cmd_d;
    end
  end

  always_comb begin
    case (addr)
      OFF_SRC: rdata = src_q;
      OFF_DST: rdata = dst_q;
      OFF_CNT: rdata = cnt_q;
      OFF_CMD: rdata = cmd_q;
      default: rdata = '0;
    endcase
  end

  assign cmd_run = cmd_q[CMD_RUN];
  assign cmd_dir = cmd_q[CMD_DIR];
  assign cmd_ien = cmd_q[CMD_IEN];
  assign cmd_err = cmd_q[CMD_ERR];
endmodule

// File: rtl/dma_eng_window.sv
module dma_eng_window #(
  parameter logic [63:0] WIN_BASE  = 64'h4_0000,
  parameter int          BUF_BYTES = 4096,
  localparam int         BUF_AW    = $clog2(BUF_BYTES)
) (
  input  logic [63:0]       laddr,
  input  logic [63:0]       count,
  output logic              ok,
  output logic [BUF_AW-1:0] offset
);
  localparam logic [63:0] WIN_END = WIN_BASE + 64'(BUF_BYTES);
  logic [63:0] end_a;

  assign end_a  = laddr + count;
  assign ok     = (laddr >= WIN_BASE) && (laddr < WIN_END) &&
                  (end_a > laddr) && (end_a <= WIN_END);
  assign offset = BUF_AW'(laddr - WIN_BASE);
endmodule

// File: rtl/dma_eng_lbuf.sv
module dma_eng_lbuf #(
  parameter int  BUF_BYTES = 4096,
  localparam int AW        = $clog2(BUF_BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/dma_timed_engine.sv
module dma_timed_engine
  import dma_eng_pkg::*;
#(
  parameter int          START_DELAY = 8,
  parameter int          BUF_BYTES   = 4096,
  parameter logic [63:0] WIN_BASE    = 64'h4_0000,
  parameter logic [63:0] HOST_MASK   = 64'h0FFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_wr_wide,
  input  logic [7:0]  reg_addr,
  input  logic [63:0] reg_wdata,
  output logic [63:0] reg_rdata,
  output logic        hm_req_valid,
  input  logic        hm_req_ready,
  output logic        hm_req_write,
  output logic [63:0] hm_req_addr,
  output logic [7:0]  hm_req_wdata,
  input  logic        hm_rsp_valid,
  input  logic [7:0]  hm_rsp_data,
  output logic [31:0] irq_set
);
  localparam int BUF_AW = $clog2(BUF_BYTES);
  localparam int IDX_W  = BUF_AW + 1;
  localparam int TMR_W  = (START_DELAY < 2) ? 1 : $clog2(START_DELAY + 1);

  logic [1:0] rst_sync;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic [63:0] src_r, dst_r, cnt_r;
  logic        cmd_run, cmd_dir, cmd_ien, cmd_err, start;
  logic        clr_run, set_err;

  dma_eng_regs u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(reg_wr_en), .wr_wide(reg_wr_wide),
    .addr(reg_addr), .wdata(reg_wdata), .clr_run(clr_run), .set_err(set_err),
    .rdata(reg_rdata), .src_q(src_r), .dst_q(dst_r), .cnt_q(cnt_r),
    .cmd_run(cmd_run), .cmd_dir(cmd_dir), .cmd_ien(cmd_ien), .cmd_err(cmd_err),
    .start(start)
  );

  logic [63:0]       local_addr, host_base;
  logic              range_ok;
  logic [BUF_AW-1:0] buf_off, buf_addr;

  assign local_addr = cmd_dir ? src_r : dst_r;
  assign host_base  = cmd_dir ? dst_r : src_r;

  dma_eng_window #(.WIN_BASE(WIN_BASE), .BUF_BYTES(BUF_BYTES)) u_win (
    .laddr(local_addr), .count(cnt_r), .ok(range_ok), .offset(buf_off)
  );

  dma_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             irq_q, irq_d;
  logic             buf_we, last_byte;
  logic [7:0]       buf_rdata;

  assign buf_addr = buf_off + idx_q[BUF_AW-1:0];

  dma_eng_lbuf #(.BUF_BYTES(BUF_BYTES)) u_lbuf (
    .clk(clk), .we(buf_we), .addr(buf_addr), .wdata(hm_rsp_data),
    .rdata(buf_rdata)
  );

  assign last_byte = (idx_q == (cnt_r[IDX_W-1:0] - IDX_W'(1)));

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    idx_d   = idx_q;
    irq_d   = 1'b0;
    clr_run = 1'b0;
    set_err = 1'b0;
    buf_we  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_WAIT;
        tmr_d   = '0;
      end
      ST_WAIT: begin
        if (tmr_q == TMR_W'(START_DELAY - 1)) state_d = ST_CHECK;
        else                                  tmr_d   = tmr_q + TMR_W'(1);
      end
      ST_CHECK: begin
        idx_d = '0;
        if (!range_ok) begin
          clr_run = 1'b1;
          set_err = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = cmd_dir ? ST_WR_REQ : ST_RD_REQ;
        end
      end
      ST_RD_REQ: if (hm_req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: if (hm_rsp_valid) begin
        buf_we = 1'b1;
        if (last_byte) begin
          clr_run = 1'b1;
          irq_d   = cmd_ien;
          state_d = ST_IDLE;
        end else begin
          idx_d   = idx_q + IDX_W'(1);
          state_d = ST_RD_REQ;
        end
      end
      ST_WR_REQ: if (hm_req_ready) begin
        if (last_byte) begin
          clr_run = 1'b1;
          irq_d   = cmd_ien;
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      idx_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      idx_q   <= idx_d;
      irq_q   <= irq_d;
    end
  end

  assign hm_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign hm_req_write = (state_q == ST_WR_REQ);
  assign hm_req_addr  = (host_base + 64'(idx_q)) & HOST_MASK;
  assign hm_req_wdata = buf_rdata;
  assign irq_set      = 32'(irq_q) << IRQ_DONE_BIT;
endmodule

// File: rtl/dma_timed_engine_chk.sv
module dma_timed_engine_chk #(
  parameter int          START_DELAY = 8,
  parameter logic [63:0] HOST_MASK   = 64'h0FFF_FFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run,
  input logic        err,
  input logic [63:0] src,
  input logic [63:0] dst,
  input logic [63:0] cnt,
  input logic        hm_req_valid,
  input logic [63:0] hm_req_addr,
  input logic [31:0] irq_set
);
  localparam int SW = $clog2(START_DELAY + 2) + 1;
  logic [SW-1:0] since_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_run <= '0;
    else if (!run)               since_run <= '0;
    else if (since_run != '1)    since_run <= since_run + SW'(1);
  end

  assert_regs_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(src) && $stable(dst) && $stable(cnt)));

  assert_no_req_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !hm_req_valid);

  assert_addr_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hm_req_valid |-> ((hm_req_addr & ~HOST_MASK) == 64'h0));

  assert_start_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hm_req_valid |-> (since_run >= SW'(START_DELAY + 1)));

  assert_irq_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != 32'h0) |-> ((irq_set == 32'h0000_0100) && $fell(run)));

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ((irq_set == 32'h0) && !run));
endmodule

bind dma_timed_engine dma_timed_engine_chk #(
  .START_DELAY(START_DELAY), .HOST_MASK(HOST_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run(cmd_run), .err(cmd_err),
  .src(src_r), .dst(dst_r), .cnt(cnt_r),
  .hm_req_valid(hm_req_valid), .hm_req_addr(hm_req_addr), .irq_set(irq_set)
);

// File: tb/dma_timed_engine_tb.sv
module dma_timed_engine_tb;
  localparam int          DLY  = 5;
  localparam logic [63:0] MASK = 64'h0FFF_FFFF;
  localparam logic [63:0] WB   = 64'h4_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, reg_wr_wide;
  logic [7:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        hm_req_valid, hm_req_ready, hm_req_write;
  logic [63:0] hm_req_addr;
  logic [7:0]  hm_req_wdata, hm_rsp_data;
  logic        hm_rsp_valid;
  logic [31:0] irq_set;

  always #10 clk = ~clk;

  dma_timed_engine #(.START_DELAY(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_wide(reg_wr_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hm_req_valid(hm_req_valid), .hm_req_ready(hm_req_ready),
    .hm_req_write(hm_req_write), .hm_req_addr(hm_req_addr),
    .hm_req_wdata(hm_req_wdata), .hm_rsp_valid(hm_rsp_valid),
    .hm_rsp_data(hm_rsp_data), .irq_set(irq_set)
  );

  int nchk = 0, nfail = 0, req_cnt = 0, irq_cnt = 0, mask_bad = 0;
  bit finished = 0, stall_on = 0;
  logic [7:0] hmem [logic [63:0]];
  bit pend = 0;
  int pdly = 0;
  logic [7:0] pdat;

  function automatic logic [7:0] host_val(input logic [63:0] a);
    if (hmem.exists(a)) return hmem[a];
    return a[7:0] ^ (a[15:8] * 8'd13) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // host memory model
  always @(posedge clk) begin
    hm_rsp_valid <= 1'b0;
    if (!rst_n) pend = 0;
    else begin
      if (pend) begin
        if (pdly == 0) begin
          hm_rsp_valid <= 1'b1;
          hm_rsp_data  <= pdat;
          pend = 0;
        end else pdly--;
      end
      if (hm_req_valid && hm_req_ready) begin
        req_cnt++;
        if ((hm_req_addr & ~MASK) != 0) mask_bad++;
        if (hm_req_write) hmem[hm_req_addr] = hm_req_wdata;
        else begin
          pend = 1;
          pdly = $urandom % 3;
          pdat = host_val(hm_req_addr);
        end
      end
    end
  end

  always @(negedge clk) begin
    hm_req_ready <= stall_on ? (($urandom % 4) != 0) : 1'b1;
    if (rst_n && irq_set != 0) irq_cnt++;
  end

  task automatic wr(input logic [7:0] a, input logic [63:0] d, input bit wide);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_wide = wide; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done(output logic [63:0] c, output logic [31:0] irq_now);
    for (int k = 0; k < 40000; k++) begin
      rd(8'h98, c);
      if (!c[0]) break;
      @(negedge clk);
    end
    irq_now = irq_set;
  endtask

  // one command; returns final command value
  task automatic do_xfer(input bit dir, input logic [63:0] la, input logic [63:0] ha,
                         input logic [63:0] cnt, input bit ien, input bit ok_exp,
                         output logic [63:0] c);
    int n, r0, i0;
    logic [31:0] irq_now;
    logic [63:0] sv, dv;
    sv = dir ? la : ha;
    dv = dir ? ha : la;
    wr(8'h80, sv, (sv[63:32] != 0) || $urandom % 2);
    wr(8'h88, dv, (dv[63:32] != 0) || $urandom % 2);
    wr(8'h90, cnt, (cnt[63:32] != 0) || $urandom % 2);
    r0 = req_cnt; i0 = irq_cnt;
    wr(8'h98, {61'h0, ien, dir, 1'b1}, $urandom % 2);
    n = 1;
    for (int k = 0; k < DLY + 20; k++) begin
      rd(8'h98, c);
      if (!c[0] || hm_req_valid) break;
      @(negedge clk); n++;
    end
    if (ok_exp) chk(n == DLY + 2, "R9 start delay", n, DLY + 2);
    wait_done(c, irq_now);
    chk(irq_now == ((ien && ok_exp) ? 32'h100 : 32'h0), "R11 irq with done", irq_now,
        (ien && ok_exp) ? 32'h100 : 32'h0);
    @(negedge clk);
    chk(irq_cnt - i0 == int'(ien && ok_exp), "R11 single pulse", irq_cnt - i0,
        int'(ien && ok_exp));
    if (!ok_exp) begin
      chk(req_cnt == r0, "R7 no host traffic", req_cnt - r0, 0);
      chk(c[3] == 1'b1 && c[0] == 1'b0, "R6 R7 rejected range", c, {c[63:4], 4'b1000});
    end else begin
      chk(c[3] == 1'b0, "R6 range accepted", c, {c[63:4], 4'b0000});
    end
  endtask

  task automatic pair(input logic [63:0] la, input logic [63:0] hin,
                      input logic [63:0] hout, input logic [63:0] cnt, input bit ien);
    logic [7:0] exp [$];
    logic [63:0] c;
    int bad;
    logic [63:0] ba, be, a;
    exp.delete();
    for (int i = 0; i < int'(cnt); i++) exp.push_back(host_val((hin + i) & MASK));
    do_xfer(1'b0, la, hin, cnt, ien, 1'b1, c);
    do_xfer(1'b1, la, hout, cnt, ien, 1'b1, c);
    bad = 0; ba = 0; be = 0;
    for (int i = 0; i < int'(cnt); i++) begin
      a = (hout + i) & MASK;
      if (!hmem.exists(a) || hmem[a] !== exp[i]) begin
        if (bad == 0) begin ba = hmem.exists(a) ? 64'(hmem[a]) : 64'hX; be = 64'(exp[i]); end
        bad++;
      end
    end
    chk(bad == 0, "R5 R8 R10 data round trip", ba, be);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, c, s0, c0;
    int r0;
    void'($urandom(32'd7155));
    rst_n = 1'b0; reg_wr_en = 0; reg_wr_wide = 0; reg_addr = 0; reg_wdata = 0;
    hm_req_ready = 1'b1; hm_rsp_valid = 1'b0; hm_rsp_data = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(8'h80 + 8'(i * 8), v);
      chk(v == 0, "R1 reset register", v, 0);
    end
    chk(!hm_req_valid && irq_set == 0, "R1 reset outputs", {hm_req_valid, irq_set}, 0);

    // R2 access widths
    wr(8'h80, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1); rd(8'h80, v);
    chk(v == 64'hFFFF_FFFF_FFFF_FFFF, "R2 wide write", v, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(8'h80, 64'hAAAA_BBBB_1234_5678, 1'b0); rd(8'h80, v);
    chk(v == 64'h1234_5678, "R2 narrow write zero-extends", v, 64'h1234_5678);
    wr(8'h90, 64'h0123_4567_89AB_CDEF, 1'b1); rd(8'h90, v);
    chk(v == 64'h0123_4567_89AB_CDEF, "R2 count reg", v, 64'h0123_4567_89AB_CDEF);

    // directed round trips, irq on and off
    pair(WB, 64'h1000, 64'h2000, 16, 1'b1);
    pair(WB + 64'h100, 64'h3000, 64'h3800, 40, 1'b0);

    // R4 command without run bit
    rd(8'h98, c0); r0 = req_cnt;
    wr(8'h98, 64'h6, 1'b1);
    repeat (DLY + 6) @(negedge clk);
    rd(8'h98, c);
    chk(c == c0, "R4 command without run ignored", c, c0);
    chk(req_cnt == r0, "R4 no transfer", req_cnt - r0, 0);

    // R3 lock while running
    wr(8'h80, 64'h5000, 1'b1); wr(8'h88, WB, 1'b1); wr(8'h90, 64'd24, 1'b1);
    wr(8'h98, 64'h1, 1'b1);
    wr(8'h80, 64'hDEAD, 1'b1); wr(8'h90, 64'd3, 1'b0); wr(8'h98, 64'h3, 1'b1);
    wait_done(c, v[31:0]);
    rd(8'h80, s0); chk(s0 == 64'h5000, "R3 source locked", s0, 64'h5000);
    rd(8'h90, v);  chk(v == 64'd24, "R3 count locked", v, 24);
    chk(c == 64'h0, "R3 command locked", c, 0);

    // R6/R7 range corners
    do_xfer(1'b0, WB, 64'h100, 0, 1'b1, 1'b0, c);
    do_xfer(1'b0, WB - 1, 64'h100, 2, 1'b1, 1'b0, c);
    do_xfer(1'b1, WB + 64'hFF0, 64'h100, 17, 1'b1, 1'b0, c);
    do_xfer(1'b0, WB + 64'h10, 64'h100, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, c);
    wr(8'h80, 64'h77, 1'b1); rd(8'h98, c);
    chk(c[3] == 1'b1, "R7 error bit sticky", c, c | 64'h8);
    pair(WB + 64'hFF0, 64'h6000, 64'h6100, 16, 1'b1);
    pair(WB + 64'hFFF, 64'h6200, 64'h6300, 1, 1'b1);

    // R8 mask truncation and wrap
    pair(WB + 64'h20, 64'hFFFF_FFF0_0FFF_FFF8, 64'h1234_0000_0FFF_FFFC, 16, 1'b1);

    // random stimulus with stalls
    stall_on = 1;
    for (int t = 0; t < 24; t++) begin
      logic [63:0] off, cn, hi, ho;
      off = 64'($urandom % 4096);
      cn  = 64'(1 + ($urandom % 32));
      if (off + cn > 4096) cn = 4096 - off;
      hi = {$urandom, $urandom};
      ho = {$urandom, $urandom};
      pair(WB + off, hi, ho, cn, 1'(($urandom % 2)));
    end
    stall_on = 0;

    chk(mask_bad == 0, "R8 masked host address", mask_bad, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule